// File: doc/BRIEF.md
# Presentation Timestamp Sync Controller

This block holds a local 33-bit time base that advances on each pulse of a 90 kHz tick enable. Clock-reference events arriving from the stream overwrite it. Each decoded picture arrives as a one-cycle event that may carry a 33-bit presentation timestamp. The block compares that stamp with the time base and returns a verdict for the picture: show it, drop it, or keep showing the previous picture.

The comparison uses the signed difference taken modulo 2^33, so it stays correct when the time base wraps. A programmable tolerance makes stamps close to the time base count as on time. A stale flag rises when the stream has gone too long without a clock reference.

Top module: `pts_sync_ctrl`

## Requirements
- R1: `stc_o` advances by exactly one in the cycle after `tick_i` is high, wraps from 2^33-1 to 0, and holds its value when neither `tick_i` nor `ref_load_i` is high.
- R2: In the cycle after `ref_load_i` is high, `stc_o` equals `ref_value_i`. A load takes priority over a tick in the same cycle.
- R3: If a stamped picture's timestamp is earlier than the time base by more than `tol_i`, the verdict is drop, code 2'b01.
- R4: If a stamped picture's timestamp is later than the time base by more than `tol_i`, the verdict is repeat-previous, code 2'b10.
- R5: If the distance between timestamp and time base is at most `tol_i` (inclusive), the verdict is show, code 2'b00. With `tol_i` = 0 only an exact match qualifies.
- R6: A picture with `pic_has_ts_i` low gets the verdict show (2'b00), whatever `pic_ts_i` holds.
- R7: `dec_valid_o` is high for exactly the cycle after each cycle in which `pic_valid_i` is high, and low otherwise. The verdict compares against the `stc_o` value present in the cycle of `pic_valid_i`, before any tick or load in that cycle takes effect.
- R8: Earlier and later are decided by the sign of (timestamp − time base) in 33-bit two's complement. A stamp a few counts past the wrap point is therefore later than a time base just below 2^33.
- R9: `ref_stale_o` rises once STALE_TICKS (default 63000) ticks have been counted with no clock-reference load since the last load or reset. It stays high through further ticks and drops in the cycle after a load.
- R10: While reset is held, and right after it, `stc_o` is 0, `dec_valid_o` is 0 and `ref_stale_o` is 0.
- R11: `dec_o` never presents code 2'b11 while `dec_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 90 kHz time-base enable, one cycle per tick |
| ref_load_i | input | 1 | Clock-reference load strobe |
| ref_value_i | input | 33 | Clock-reference value to load |
| tol_i | input | 16 | Match tolerance in ticks |
| pic_valid_i | input | 1 | Decoded picture event |
| pic_has_ts_i | input | 1 | Picture carries a timestamp |
| pic_ts_i | input | 33 | Picture presentation timestamp |
| stc_o | output | 33 | Current local time base |
| dec_valid_o | output | 1 | Verdict strobe |
| dec_o | output | 2 | Verdict: 00 show, 01 drop, 10 repeat previous |
| ref_stale_o | output | 1 | No clock reference within the allowed window |

## Verification
The assertions check the time-base arithmetic on every cycle: increment, hold, wrap and load priority. They also check the verdict strobe timing, the show verdict for unstamped pictures, the legality of the verdict code, and how the stale flag clears and persists. Only the bench scenarios show the verdict for a given stamp at the tolerance edges and across the wrap point. The same holds for the exact tick count at which the stale flag first rises, and for the use of the pre-tick time base when a picture and a tick coincide.

// File: rtl/pts_sync_pkg.sv
package pts_sync_pkg;
  // Verdict encoding seen on dec_o
  typedef enum logic [1:0] {
    VERDICT_SHOW   = 2'b00,
    VERDICT_DROP   = 2'b01,
    VERDICT_REPEAT = 2'b10
  } verdict_e;
endpackage

// File: rtl/stc_timebase.sv
module stc_timebase #(
  parameter int TS_W = 33
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic [TS_W-1:0] load_val_i,
  output logic [TS_W-1:0] stc_o
);
  logic [TS_W-1:0] stc_q;
  logic [TS_W-1:0] stc_d;
  logic            stc_en;

  // Load wins over tick; increment wraps naturally modulo 2^TS_W
  always_comb begin
    stc_en = load_i | tick_i;
    if (load_i) stc_d = load_val_i;
    else        stc_d = stc_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stc_q <= '0;
    else if (stc_en) stc_q <= stc_d;
  end

  assign stc_o = stc_q;
endmodule

// File: rtl/ts_judge.sv
module ts_judge
  import pts_sync_pkg::*;
#(
  parameter int TS_W  = 33,
  parameter int TOL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pic_valid_i,
  input  logic             has_ts_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [TS_W-1:0]  stc_i,
  input  logic [TOL_W-1:0] tol_i,
  output logic             dec_valid_o,
  output logic [1:0]       dec_o
);
  logic [TS_W-1:0] diff;
  logic            behind;
  logic [TS_W-1:0] mag;
  logic [TS_W-1:0] tol_ext;
  logic            near;
  verdict_e        verdict_d;
  verdict_e        verdict_q;
  logic            valid_q;

  // Fit the tolerance to the stamp width
  generate
    if (TOL_W >= TS_W) begin : g_tol_trunc
      assign tol_ext = tol_i[TS_W-1:0];
    end else begin : g_tol_zext
      assign tol_ext = {{(TS_W-TOL_W){1'b0}}, tol_i};
    end
  endgenerate

  // Wrap-aware signed distance from the time base to the stamp
  always_comb begin
    diff   = ts_i - stc_i;
    behind = diff[TS_W-1];
    mag    = behind ? (~diff + TS_W'(1)) : diff;
    near   = (mag <= tol_ext);
    if (!has_ts_i)   verdict_d = VERDICT_SHOW;
    else if (near)   verdict_d = VERDICT_SHOW;
    else if (behind) verdict_d = VERDICT_DROP;
    else             verdict_d = VERDICT_REPEAT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= VERDICT_SHOW;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= pic_valid_i;
      if (pic_valid_i) verdict_q <= verdict_d;
    end
  end

  assign dec_valid_o = valid_q;
  assign dec_o       = verdict_q;
endmodule

// File: rtl/ref_watchdog.sv
module ref_watchdog #(
  parameter int LIMIT = 63000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic load_i,
  output logic stale_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Saturating count of ticks since the last reference load
  always_comb begin
    cnt_en = load_i | (tick_i && (cnt_q != CNT_MAX));
    if (load_i) cnt_d = '0;
    else        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign stale_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pts_sync_ctrl.sv
module pts_sync_ctrl #(
  parameter int TS_W        = 33,
  parameter int TOL_W       = 16,
  parameter int STALE_TICKS = 63000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ref_load_i,
  input  logic [TS_W-1:0]  ref_value_i,
  input  logic [TOL_W-1:0] tol_i,
  input  logic             pic_valid_i,
  input  logic             pic_has_ts_i,
  input  logic [TS_W-1:0]  pic_ts_i,
  output logic [TS_W-1:0]  stc_o,
  output logic             dec_valid_o,
  output logic [1:0]       dec_o,
  output logic             ref_stale_o
);
  logic [TS_W-1:0] stc_w;

  stc_timebase #(.TS_W(TS_W)) u_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (ref_load_i),
    .load_val_i (ref_value_i),
    .stc_o      (stc_w)
  );

  ts_judge #(.TS_W(TS_W), .TOL_W(TOL_W)) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .pic_valid_i (pic_valid_i),
    .has_ts_i    (pic_has_ts_i),
    .ts_i        (pic_ts_i),
    .stc_i       (stc_w),
    .tol_i       (tol_i),
    .dec_valid_o (dec_valid_o),
    .dec_o       (dec_o)
  );

  ref_watchdog #(.LIMIT(STALE_TICKS)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .load_i  (ref_load_i),
    .stale_o (ref_stale_o)
  );

  assign stc_o = stc_w;
endmodule

// File: rtl/pts_sync_chk.sv
module pts_sync_chk #(
  parameter int TS_W = 33
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            ref_load_i,
  input logic [TS_W-1:0] ref_value_i,
  input logic            pic_valid_i,
  input logic            pic_has_ts_i,
  input logic [TS_W-1:0] stc_o,
  input logic            dec_valid_o,
  input logic [1:0]      dec_o,
  input logic            ref_stale_o
);
  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ref_load_i) |=> (stc_o == TS_W'($past(stc_o) + TS_W'(1)))); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ref_load_i) |=> $stable(stc_o)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_load_i |=> (stc_o == $past(ref_value_i))); // R2
  AST_UNSTAMPED_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pic_valid_i && !pic_has_ts_i) |=> (dec_o == 2'b00)); // R6
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pic_valid_i |=> dec_valid_o); // R7
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !pic_valid_i |=> !dec_valid_o); // R7
  AST_STALE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_load_i |=> !ref_stale_o); // R9
  AST_STALE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stale_o && !ref_load_i) |=> ref_stale_o); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> (dec_o != 2'b11)); // R11
endmodule

bind pts_sync_ctrl pts_sync_chk #(.TS_W(TS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .ref_load_i   (ref_load_i),
  .ref_value_i  (ref_value_i),
  .pic_valid_i  (pic_valid_i),
  .pic_has_ts_i (pic_has_ts_i),
  .stc_o        (stc_o),
  .dec_valid_o  (dec_valid_o),
  .dec_o        (dec_o),
  .ref_stale_o  (ref_stale_o)
);

// File: tb/sim_pts_sync_ctrl.sv
module sim_pts_sync_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        ref_load_i;
  logic [32:0] ref_value_i;
  logic [15:0] tol_i;
  logic        pic_valid_i;
  logic        pic_has_ts_i;
  logic [32:0] pic_ts_i;
  logic [32:0] stc_o;
  logic        dec_valid_o;
  logic [1:0]  dec_o;
  logic        ref_stale_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [32:0] exp_stc;

  always #4 clk = ~clk;

  pts_sync_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ref_load_i(ref_load_i),
    .ref_value_i(ref_value_i), .tol_i(tol_i), .pic_valid_i(pic_valid_i),
    .pic_has_ts_i(pic_has_ts_i), .pic_ts_i(pic_ts_i), .stc_o(stc_o),
    .dec_valid_o(dec_valid_o), .dec_o(dec_o), .ref_stale_o(ref_stale_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance one edge; sample and drive 1 ns after it
  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] want(input logic has, input logic [32:0] ts,
                                      input logic [32:0] base, input logic [15:0] tol);
    logic [32:0] d;
    longint s;
    d = ts - base;
    s = longint'({{31{d[32]}}, d});
    if (!has) return 2'b00;
    if (s <= longint'(tol) && s >= -longint'(tol)) return 2'b00;
    return (s < 0) ? 2'b01 : 2'b10;
  endfunction

  task automatic do_ticks(input int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) cyc();
    tick_i = 1'b0;
    exp_stc = exp_stc + 33'(n);
  endtask

  task automatic do_load(input logic [32:0] v);
    ref_load_i = 1'b1; ref_value_i = v;
    cyc();
    ref_load_i = 1'b0;
    exp_stc = v;
  endtask

  task automatic do_pic(input string req, input logic has, input logic [32:0] ts);
    pic_valid_i = 1'b1; pic_has_ts_i = has; pic_ts_i = ts;
    cyc();
    pic_valid_i = 1'b0;
    check({req, " strobe"}, 64'(dec_valid_o), 64'd1);
    check({req, " verdict"}, 64'(dec_o), 64'(want(has, ts, exp_stc, tol_i)));
  endtask

  task automatic t_reset;
    check("R10 stc", 64'(stc_o), 64'd0);
    check("R10 strobe", 64'(dec_valid_o), 64'd0);
    check("R10 stale", 64'(ref_stale_o), 64'd0);
  endtask

  task automatic t_count;
    do_ticks(5);
    check("R1 count", 64'(stc_o), 64'(exp_stc));
    cyc(); cyc();
    check("R1 hold", 64'(stc_o), 64'(exp_stc));
  endtask

  task automatic t_load;
    do_load(33'd1000);
    check("R2 load", 64'(stc_o), 64'd1000);
    tick_i = 1'b1;
    do_load(33'd1000);
    tick_i = 1'b0;
    check("R2 load over tick", 64'(stc_o), 64'd1000);
  endtask

  task automatic t_decide;
    tol_i = 16'd0;
    do_pic("R3 drop", 1'b1, 33'd999);
    do_pic("R4 repeat", 1'b1, 33'd1001);
    do_pic("R5 exact", 1'b1, 33'd1000);
    tol_i = 16'd3;
    do_pic("R5 edge late", 1'b1, 33'd1003);
    do_pic("R4 past tol", 1'b1, 33'd1004);
    do_pic("R5 edge early", 1'b1, 33'd997);
    do_pic("R3 past tol", 1'b1, 33'd996);
    do_pic("R6 unstamped", 1'b0, 33'd5);
    cyc();
    check("R7 strobe drops", 64'(dec_valid_o), 64'd0);
    // picture and tick together: compare uses pre-tick base
    tol_i = 16'd0;
    tick_i = 1'b1;
    do_pic("R7 pre-tick base", 1'b1, 33'd1000);
    tick_i = 1'b0;
    exp_stc = exp_stc + 33'd1;
    check("R7 tick applied", 64'(stc_o), 64'(exp_stc));
  endtask

  task automatic t_wrap;
    do_load(33'h1_FFFF_FFFE);
    do_ticks(2);
    check("R1 wrap", 64'(stc_o), 64'd0);
    do_load(33'h1_FFFF_FFFF);
    do_pic("R8 stamp past wrap", 1'b1, 33'd1);
    do_load(33'd1);
    do_pic("R8 base past wrap", 1'b1, 33'h1_FFFF_FFFF);
  endtask

  task automatic t_stale;
    do_load(33'd50);
    do_ticks(62999);
    check("R9 not yet stale", 64'(ref_stale_o), 64'd0);
    do_ticks(1);
    check("R9 stale", 64'(ref_stale_o), 64'd1);
    do_ticks(3);
    check("R9 stays stale", 64'(ref_stale_o), 64'd1);
    do_load(33'd7);
    check("R9 load clears", 64'(ref_stale_o), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; ref_load_i = 1'b0; ref_value_i = '0;
    tol_i = '0; pic_valid_i = 1'b0; pic_has_ts_i = 1'b0; pic_ts_i = '0;
    exp_stc = '0;
    cyc(); cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_count();
    t_load();
    t_decide();
    t_wrap();
    t_stale();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule